// File: doc/BRIEF.md
# Scoreboard Hazard Controller

This block is the central scheduling controller of a small machine that has several functional units, none of them pipelined. Each cycle it may accept one decoded instruction, which names a target unit, a destination register and two source registers. The instruction then moves through four ordered phases: issue, operand read, execute and result write. The controller decides when each phase may happen. Each kind of hazard is handled by holding the instruction in one specific phase. Nothing is renamed and nothing is forwarded.

Issue is held while the target unit is occupied, or while another instruction in flight will still write the same destination. An issued instruction reads its operands only after neither source is waiting for a result. Because of this, instructions can start out of program order. When a unit finishes, it reports completion. Its result write is then held for as long as an earlier instruction still needs the old contents of that register. A per-register table records which unit will produce each register's next value. The functional units are modelled as fixed-latency stubs inside the block.

Top module: `sb_ctrl`

## Requirements
- R1: After reset, no register is pending and no unit is busy: `in_stall` is 0 for any presented instruction, and `rf_rd_en`, `rf_wr_en` and `rf_wr_unit` are all 0.
- R2: An instruction whose unit (`in_unit`, the unit index 0 to 3) is busy is not issued. It issues in the cycle after that unit's result write.
- R3: An instruction whose destination is still pending from an in-flight instruction is not issued. It issues in the cycle after that write. The later write then targets that same register.
- R4: An issued instruction whose source is pending reads its operands in the cycle after the producer's result write, and not earlier.
- R5: Take an instruction presented without a hazard in cycle c on a unit of latency L. It issues at the end of cycle c, asserts its `rf_rd_en` bit in cycle c+1, and is granted its write in cycle c+2+L, with `rf_wr_reg` equal to its destination.
- R6: Units 0, 1, 2 and 3 have execution latencies of 1, 2, 4 and 8 cycles. A unit's `fu_done` bit pulses L cycles after its operand read.
- R7: Independent instructions complete out of order. A later instruction on a faster unit writes before an earlier one on a slower unit.
- R8: A finished unit does not write its destination while another busy unit holds that register as a source that is ready but not yet read. The write is granted in the cycle after that read.
- R9: When several units may write in the same cycle, the one with the lowest index is granted. The others follow in later cycles. At most one write happens per cycle.
- R10: Hazard-free instructions issue back to back, one per cycle, in the order presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Decoded instruction present |
| in_unit | input | 2 | Target functional unit index |
| in_dst | input | 3 | Destination register |
| in_src1 | input | 3 | First source register |
| in_src2 | input | 3 | Second source register |
| in_stall | output | 1 | Presented instruction cannot issue this cycle |
| rf_rd_en | output | 4 | Per-unit operand read grant (execution starts) |
| fu_done | output | 4 | Per-unit execution completion pulse |
| rf_wr_en | output | 1 | Register write this cycle |
| rf_wr_reg | output | 3 | Register being written |
| rf_wr_unit | output | 4 | One-hot unit whose result is written |

## Verification
The bench uses the default parameters: four units with latencies of 1, 2, 4 and 8 cycles, and eight registers. Because the latencies differ, a short instruction issued after a long one can finish first. Pairs of units can also be made to finish in the same cycle, which exercises write arbitration. The eight-cycle unit gives windows long enough to hold instructions at issue, at operand read and at result write, and the bench checks the exact release cycle of each hold.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int NUM_FU  = 4;
  localparam int NUM_REG = 8;
  localparam int FU_W    = $clog2(NUM_FU);
  localparam int REG_W   = $clog2(NUM_REG);
  localparam int CNT_W   = 8;

  typedef logic [FU_W-1:0]  fu_id_t;
  typedef logic [REG_W-1:0] reg_id_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_READ = 2'd1,
    PH_EXEC = 2'd2,
    PH_WB   = 2'd3
  } phase_e;
endpackage

// File: rtl/sb_fu_stub.sv
module sb_fu_stub
  import sb_pkg::*;
#(
  parameter int unsigned LAT = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic done
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;

  assign done = run_q && (cnt_q == CNT_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    if (start) begin
      cnt_d = CNT_W'(LAT);
      run_d = 1'b1;
    end else if (run_q) begin
      cnt_d = cnt_q - CNT_W'(1);
      if (done) run_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  // R6: a unit is never restarted while it is still executing
  a_r6_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !run_q);
endmodule

// File: rtl/sb_wb_arb.sv
module sb_wb_arb #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  logic taken;

  always_comb begin
    grant = '0;
    taken = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !taken) begin
        grant[i] = 1'b1;
        taken    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sb_slot.sv
module sb_slot
  import sb_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    iss_en,
  input  reg_id_t iss_fi,
  input  reg_id_t iss_fj,
  input  reg_id_t iss_fk,
  input  fu_id_t  iss_qj,
  input  fu_id_t  iss_qk,
  input  logic    iss_rj,
  input  logic    iss_rk,
  input  logic    ex_done,
  input  logic    wb_go,
  input  logic    bc_en,
  input  fu_id_t  bc_fu,
  output logic    busy,
  output reg_id_t fi,
  output reg_id_t fj,
  output reg_id_t fk,
  output logic    rj,
  output logic    rk,
  output logic    rd_go,
  output logic    wb_req
);
  phase_e  ph_q, ph_d;
  fu_id_t  qj_q, qk_q;
  logic    rj_d, rk_d;
  logic    ld;

  assign busy   = (ph_q != PH_IDLE);
  assign rd_go  = (ph_q == PH_READ) && rj && rk;
  assign wb_req = (ph_q == PH_WB);
  assign ld     = iss_en && (ph_q == PH_IDLE);

  always_comb begin
    ph_d = ph_q;
    rj_d = rj;
    rk_d = rk;
    unique case (ph_q)
      PH_IDLE: if (iss_en) begin
        ph_d = PH_READ;
        rj_d = iss_rj;
        rk_d = iss_rk;
      end
      PH_READ: begin
        if (rd_go) begin
          ph_d = PH_EXEC;
          rj_d = 1'b0;
          rk_d = 1'b0;
        end else if (bc_en) begin
          if (!rj && qj_q == bc_fu) rj_d = 1'b1;
          if (!rk && qk_q == bc_fu) rk_d = 1'b1;
        end
      end
      PH_EXEC: if (ex_done) ph_d = PH_WB;
      PH_WB:   if (wb_go)   ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE;
      rj   <= 1'b0;
      rk   <= 1'b0;
    end else begin
      ph_q <= ph_d;
      rj   <= rj_d;
      rk   <= rk_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fi   <= '0;
      fj   <= '0;
      fk   <= '0;
      qj_q <= '0;
      qk_q <= '0;
    end else if (ld) begin
      fi   <= iss_fi;
      fj   <= iss_fj;
      fk   <= iss_fk;
      qj_q <= iss_qj;
      qk_q <= iss_qk;
    end
  end

  // R2: the controller issues only into a free unit
  a_r2_issue_into_idle: assert property (@(posedge clk) disable iff (!rst_n)
    iss_en |-> ph_q == PH_IDLE);
  // R6: completion arrives only from an executing unit
  a_r6_done_while_exec: assert property (@(posedge clk) disable iff (!rst_n)
    ex_done |-> ph_q == PH_EXEC);
  // R8: a write is granted only after execution has finished
  a_r8_write_after_exec: assert property (@(posedge clk) disable iff (!rst_n)
    wb_go |-> ph_q == PH_WB);
endmodule

// File: rtl/sb_ctrl.sv
module sb_ctrl
  import sb_pkg::*;
#(
  parameter logic [NUM_FU*CNT_W-1:0] FU_LAT = {8'd8, 8'd4, 8'd2, 8'd1}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [FU_W-1:0]   in_unit,
  input  logic [REG_W-1:0]  in_dst,
  input  logic [REG_W-1:0]  in_src1,
  input  logic [REG_W-1:0]  in_src2,
  output logic              in_stall,
  output logic [NUM_FU-1:0] rf_rd_en,
  output logic [NUM_FU-1:0] fu_done,
  output logic              rf_wr_en,
  output logic [REG_W-1:0]  rf_wr_reg,
  output logic [NUM_FU-1:0] rf_wr_unit
);
  // register-result table
  logic [NUM_REG-1:0] pend_q, pend_d;
  fu_id_t             prod_q [NUM_REG];
  fu_id_t             prod_d [NUM_REG];

  logic [NUM_FU-1:0]  busy, wb_req, war_blk, wb_elig;
  reg_id_t            fi_a [NUM_FU];
  reg_id_t            fj_a [NUM_FU];
  reg_id_t            fk_a [NUM_FU];
  logic [NUM_FU-1:0]  rj_a, rk_a;

  logic    issue, iss_rj, iss_rk;
  fu_id_t  wr_idx;

  assign in_stall = busy[in_unit] || pend_q[in_dst];
  assign issue    = in_valid && !in_stall;
  assign iss_rj   = !pend_q[in_src1] || (rf_wr_en && rf_wr_reg == in_src1);
  assign iss_rk   = !pend_q[in_src2] || (rf_wr_en && rf_wr_reg == in_src2);

  // hold a write while another unit still has to read the old value
  always_comb begin
    war_blk = '0;
    for (int f = 0; f < NUM_FU; f++) begin
      for (int g = 0; g < NUM_FU; g++) begin
        if (g != f && busy[g] &&
            ((fj_a[g] == fi_a[f] && rj_a[g]) || (fk_a[g] == fi_a[f] && rk_a[g])))
          war_blk[f] = 1'b1;
      end
    end
  end

  assign wb_elig = wb_req & ~war_blk;

  sb_wb_arb #(.N(NUM_FU)) u_arb (
    .req   (wb_elig),
    .grant (rf_wr_unit)
  );

  always_comb begin
    wr_idx = '0;
    for (int i = 0; i < NUM_FU; i++)
      if (rf_wr_unit[i]) wr_idx = fu_id_t'(i);
  end

  assign rf_wr_en  = |rf_wr_unit;
  assign rf_wr_reg = fi_a[wr_idx];

  genvar gi;
  generate
    for (gi = 0; gi < NUM_FU; gi++) begin : g_unit
      sb_slot u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .iss_en  (issue && (in_unit == fu_id_t'(gi))),
        .iss_fi  (in_dst),
        .iss_fj  (in_src1),
        .iss_fk  (in_src2),
        .iss_qj  (prod_q[in_src1]),
        .iss_qk  (prod_q[in_src2]),
        .iss_rj  (iss_rj),
        .iss_rk  (iss_rk),
        .ex_done (fu_done[gi]),
        .wb_go   (rf_wr_unit[gi]),
        .bc_en   (rf_wr_en),
        .bc_fu   (wr_idx),
        .busy    (busy[gi]),
        .fi      (fi_a[gi]),
        .fj      (fj_a[gi]),
        .fk      (fk_a[gi]),
        .rj      (rj_a[gi]),
        .rk      (rk_a[gi]),
        .rd_go   (rf_rd_en[gi]),
        .wb_req  (wb_req[gi])
      );

      sb_fu_stub #(.LAT(int'(FU_LAT[gi*CNT_W +: CNT_W]))) u_fu (
        .clk   (clk),
        .rst_n (rst_n),
        .start (rf_rd_en[gi]),
        .done  (fu_done[gi])
      );
    end
  endgenerate

  always_comb begin
    pend_d = pend_q;
    for (int r = 0; r < NUM_REG; r++) prod_d[r] = prod_q[r];
    if (rf_wr_en) pend_d[rf_wr_reg] = 1'b0;
    if (issue) begin
      pend_d[in_dst] = 1'b1;
      prod_d[in_dst] = in_unit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      for (int r = 0; r < NUM_REG; r++) prod_q[r] <= '0;
    end else if (issue || rf_wr_en) begin
      pend_q <= pend_d;
      for (int r = 0; r < NUM_REG; r++) prod_q[r] <= prod_d[r];
    end
  end

  // R3: each write lands on a register the table names as owned by that unit
  a_r3_table_owner: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr_en |-> (pend_q[rf_wr_reg] && prod_q[rf_wr_reg] == wr_idx));
  // R9: at most one result write per cycle
  a_r9_single_writer: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rf_wr_unit));
endmodule

// File: tb/sb_ctrl_tb.sv
module sb_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic [1:0] in_unit;
  logic [2:0] in_dst, in_src1, in_src2;
  logic       in_stall;
  logic [3:0] rf_rd_en, fu_done, rf_wr_unit;
  logic       rf_wr_en;
  logic [2:0] rf_wr_reg;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 1'b0;
  int st_c [4];
  int dn_c [4];
  int wb_c [4];
  int wb_r [4];
  int lat [4] = '{1, 2, 4, 8};

  always #4 clk = ~clk;

  sb_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_unit(in_unit),
    .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2), .in_stall(in_stall),
    .rf_rd_en(rf_rd_en), .fu_done(fu_done), .rf_wr_en(rf_wr_en),
    .rf_wr_reg(rf_wr_reg), .rf_wr_unit(rf_wr_unit)
  );

  // event recorder: one count per cycle, taken mid-cycle
  always @(negedge clk) begin
    cyc <= cyc + 1;
    for (int i = 0; i < 4; i++) begin
      if (rf_rd_en[i])   st_c[i] <= cyc + 1;
      if (fu_done[i])    dn_c[i] <= cyc + 1;
      if (rf_wr_unit[i]) begin
        wb_c[i] <= cyc + 1;
        wb_r[i] <= int'(rf_wr_reg);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(input int u, input int d, input int s1, input int s2, output int c);
    @(negedge clk); #1;
    in_valid = 1'b1;
    in_unit  = 2'(u);
    in_dst   = 3'(d);
    in_src1  = 3'(s1);
    in_src2  = 3'(s2);
    #1;
    while (in_stall) begin
      @(negedge clk); #2;
    end
    c = cyc;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      in_valid = 1'b0;
    end
  endtask

  task automatic t_reset;
    @(negedge clk); #2;
    chk("R1 stall", int'(in_stall), 0);
    chk("R1 rd_en", int'(rf_rd_en), 0);
    chk("R1 wr_en", int'(rf_wr_en), 0);
    chk("R1 wr_unit", int'(rf_wr_unit), 0);
  endtask

  task automatic t_indep;
    int c [4];
    issue(0, 0, 4, 5, c[0]);
    issue(1, 1, 4, 6, c[1]);
    issue(2, 2, 5, 7, c[2]);
    issue(3, 3, 6, 7, c[3]);
    idle(20);
    for (int k = 1; k < 4; k++) chk("R10 back-to-back issue", c[k], c[k-1] + 1);
    for (int k = 0; k < 4; k++) begin
      chk("R5 read cycle", st_c[k], c[k] + 1);
      chk("R6 done latency", dn_c[k], c[k] + 1 + lat[k]);
      chk("R5 write cycle", wb_c[k], c[k] + 2 + lat[k]);
      chk("R5 write reg", wb_r[k], k);
    end
  endtask

  task automatic t_ooo;
    int c3, c0;
    issue(3, 4, 0, 1, c3);
    issue(0, 5, 2, 3, c0);
    idle(14);
    chk("R7 fast write first", wb_c[0], c3 + 4);
    chk("R7 slow write later", wb_c[3], c3 + 10);
  endtask

  task automatic t_struct;
    int c, c2;
    issue(3, 1, 0, 0, c);
    issue(3, 2, 0, 0, c2);
    idle(14);
    chk("R2 structural hold", c2, c + 11);
  endtask

  task automatic t_waw;
    int c, c2;
    issue(3, 6, 0, 0, c);
    issue(0, 6, 0, 0, c2);
    idle(8);
    chk("R3 WAW hold", c2, c + 11);
    chk("R3 later write cycle", wb_c[0], c2 + 3);
    chk("R3 later write reg", wb_r[0], 6);
  endtask

  task automatic t_raw;
    int c, c2;
    issue(2, 3, 0, 0, c);
    issue(0, 4, 3, 1, c2);
    idle(12);
    chk("R4 waiter issues at once", c2, c + 1);
    chk("R4 read after producer write", st_c[0], c + 7);
    chk("R4 waiter write", wb_c[0], c + 9);
  endtask

  task automatic t_war;
    int c, cg, cf;
    issue(2, 1, 0, 0, c);
    issue(3, 0, 1, 2, cg);
    issue(0, 2, 3, 3, cf);
    idle(20);
    chk("R8 producer write", wb_c[2], c + 6);
    chk("R8 reader start", st_c[3], c + 7);
    chk("R8 WAR held write", wb_c[0], c + 8);
  endtask

  task automatic t_arb;
    int c, c1, d, d1;
    issue(1, 1, 5, 5, c);
    issue(0, 2, 5, 5, c1);
    idle(8);
    chk("R9 low index first", wb_c[0], c + 4);
    chk("R9 high index next", wb_c[1], c + 5);
    issue(3, 3, 5, 5, d);
    idle(3);
    issue(2, 4, 5, 5, d1);
    idle(14);
    chk("R9 issue spacing", d1, d + 4);
    chk("R9 unit2 before unit3", wb_c[2], d + 10);
    chk("R9 unit3 after", wb_c[3], d + 11);
  endtask

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_unit = '0;
    in_dst = '0;
    in_src1 = '0;
    in_src2 = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_indep();
    t_ooo();
    t_struct();
    t_waw();
    t_raw();
    t_war();
    t_arb();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule